// File: doc/BRIEF.md
# Two-Sample Parallel First-Order Recursive Filter

This block implements the first-order recursion y[n] = x[n] + a·y[n-1] on 16-bit signed fractional data (one sign bit, fifteen fraction bits), restructured so that every clock accepts two consecutive input samples and returns two consecutive output samples. The earlier sample of the pair (`x_even`, time n-1) produces `y_even` from the carried state. The later sample (`x_odd`, time n) produces `y_odd` through the distributed form x[n] + a·x[n-1] + a²·y[n-2]. That form does not wait for `y_even`, so both outputs come from the same state in parallel. The depth is one multiply and a three-operand add rather than two chained multiply-adds.

The coefficient is written through a load strobe. On that edge the block registers both the coefficient and its square, so no squaring happens in the recursive path. The only filter state is the last `y_odd`, which feeds the next pair. A small controller has two named states. IDLE means no result is presented. EMIT means a result pair is presented for one cycle per accepted pair. Transitions: IDLE→EMIT (ACCEPT, input pair valid), EMIT→EMIT (STREAM, another pair valid), EMIT→IDLE (DRAIN, no pair valid), IDLE→IDLE (WAIT).

Top module: `iir1_pair_top`

## Requirements
- R1: A synchronous active-high `rst` clears the coefficient, its square, the filter state and both outputs to zero and drops `out_valid`. The first pair after reset therefore returns y_even = x_even and y_odd = x_odd.
- R2: When `coef_load` is high at a rising edge, `coef_in` and its rounded square become the coefficient from the next cycle on. A pair accepted on that same edge still uses the previous coefficient.
- R3: Every product is formed as the full 32-bit product p, rounded as (p + 2^14) >>> 15 (ties go toward positive infinity), then saturated to [-32768, 32767].
- R4: y_even = sat16(x_even + mul(a, s)), where s is the filter state.
- R5: y_odd = sat16(x_odd + mul(a, x_even) + mul(a², s)). The three terms are added at full width and saturated once.
- R6: An accepted pair replaces the state s with its y_odd. Without `in_valid` the state is unchanged.
- R7: `out_valid` is high in the cycle after an edge with `in_valid` high and low otherwise. `y_even` and `y_odd` hold their last values while `out_valid` is low.
- R8: The coefficient -32768 (-1.0) yields a² = 32767, because the square saturates.
- R9: For |a| ≤ 0.5 and samples in [-2048, 2047], each output stays within 4 LSB of a one-sample-at-a-time reference recursion.
- R10: A sum that exceeds the 16-bit range clamps to 32767 or -32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| coef_load | input | 1 | Strobe that loads `coef_in` |
| coef_in | input | 16 | Signed Q1.15 coefficient a |
| in_valid | input | 1 | Input pair is valid this cycle |
| x_even | input | 16 | Earlier sample of the pair, x[n-1] |
| x_odd | input | 16 | Later sample of the pair, x[n] |
| out_valid | output | 1 | Output pair is valid |
| y_even | output | 16 | Output y[n-1] |
| y_odd | output | 16 | Output y[n] |

## Verification
An accepted pair's outputs are due exactly one cycle later. A coefficient load takes effect for pairs accepted from the cycle after the strobe. The driver computes each expected pair when it presents the inputs, using its own model of coefficient and state, and queues it. The monitor samples on the falling edge after every rising edge. It pops one item whenever `out_valid` is high, flags a result that arrives with an empty queue, and checks that outputs hold through the idle cycles.

// File: rtl/iir1_pair_pkg.sv
package iir1_pair_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } emit_state_t;

endpackage

// File: rtl/iir1_qmul.sv
// Fractional multiply: full product, round half up, saturate to DW bits.
module iir1_qmul #(
    parameter int DW = 16
) (
    input  logic signed [DW-1:0] op_a,
    input  logic signed [DW-1:0] op_b,
    output logic signed [DW-1:0] prod
);
    localparam int PW   = 2 * DW;
    localparam int FRAC = DW - 1;
    localparam logic signed [PW-1:0] RND  = $signed({{(PW-1){1'b0}}, 1'b1}) <<< (FRAC - 1);
    localparam logic signed [PW-1:0] MAXV = $signed({{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}});
    localparam logic signed [PW-1:0] MINV = -MAXV - 1;

    logic signed [PW-1:0] ext_a;
    logic signed [PW-1:0] ext_b;
    logic signed [PW-1:0] full;
    logic signed [PW-1:0] scaled;

    always_comb begin
        ext_a  = op_a;
        ext_b  = op_b;
        full   = ext_a * ext_b;
        scaled = (full + RND) >>> FRAC;
        if (scaled > MAXV)
            prod = MAXV[DW-1:0];
        else if (scaled < MINV)
            prod = MINV[DW-1:0];
        else
            prod = scaled[DW-1:0];
    end
endmodule

// File: rtl/iir1_coef_unit.sv
// Holds the coefficient and its precomputed square.
module iir1_coef_unit #(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 coef_load,
    input  logic signed [DW-1:0] coef_in,
    output logic signed [DW-1:0] a_q,
    output logic signed [DW-1:0] a2_q
);
    logic signed [DW-1:0] sq_next;

    iir1_qmul #(.DW(DW)) u_square (
        .op_a (coef_in),
        .op_b (coef_in),
        .prod (sq_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q  <= '0;
            a2_q <= '0;
        end else if (coef_load) begin
            a_q  <= coef_in;
            a2_q <= sq_next;
        end
    end

    assert_coef_capture_R2: assert property (@(posedge clk) disable iff (rst)
        coef_load |=> (a_q == $past(coef_in)));

    assert_coef_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !coef_load |=> ($stable(a_q) && $stable(a2_q)));

    assert_square_nonneg_R8: assert property (@(posedge clk) disable iff (rst)
        a2_q >= 0);
endmodule

// File: rtl/iir1_emit_ctrl.sv
// Two-state controller marking when a result pair is presented.
module iir1_emit_ctrl
    import iir1_pair_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    output logic accept,
    output logic out_valid
);
    emit_state_t state_q;
    emit_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;  // ACCEPT / WAIT
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;  // STREAM / DRAIN
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        accept    = in_valid;
        out_valid = (state_q == ST_EMIT);
    end

    assert_emit_after_accept_R7: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_quiet_without_input_R7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
endmodule

// File: rtl/iir1_pair_path.sv
// Unrolled datapath: both outputs computed from the same carried state.
module iir1_pair_path #(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 accept,
    input  logic signed [DW-1:0] a_q,
    input  logic signed [DW-1:0] a2_q,
    input  logic signed [DW-1:0] x_even,
    input  logic signed [DW-1:0] x_odd,
    output logic signed [DW-1:0] y_even,
    output logic signed [DW-1:0] y_odd
);
    localparam int EW = DW + 1;
    localparam int OW = DW + 2;
    localparam int NPROD = 3;
    localparam logic signed [OW-1:0] MAXV = $signed({3'b000, {(DW-1){1'b1}}});
    localparam logic signed [OW-1:0] MINV = -MAXV - 1;

    logic signed [DW-1:0] state_q;
    logic signed [DW-1:0] mul_l [NPROD];
    logic signed [DW-1:0] mul_r [NPROD];
    logic signed [DW-1:0] mul_p [NPROD];
    logic signed [EW-1:0] sum_even;
    logic signed [OW-1:0] sum_odd;
    logic signed [DW-1:0] even_d;
    logic signed [DW-1:0] odd_d;

    // product 0: a*s, product 1: a*x_even, product 2: a^2*s
    always_comb begin
        mul_l[0] = a_q;  mul_r[0] = state_q;
        mul_l[1] = a_q;  mul_r[1] = x_even;
        mul_l[2] = a2_q; mul_r[2] = state_q;
    end

    for (genvar gi = 0; gi < NPROD; gi++) begin : g_mul
        iir1_qmul #(.DW(DW)) u_mul (
            .op_a (mul_l[gi]),
            .op_b (mul_r[gi]),
            .prod (mul_p[gi])
        );
    end

    always_comb begin
        sum_even = EW'(x_even) + EW'(mul_p[0]);
        sum_odd  = OW'(x_odd) + OW'(mul_p[1]) + OW'(mul_p[2]);
        if (OW'(sum_even) > MAXV)      even_d = MAXV[DW-1:0];
        else if (OW'(sum_even) < MINV) even_d = MINV[DW-1:0];
        else                           even_d = sum_even[DW-1:0];
        if (sum_odd > MAXV)            odd_d  = MAXV[DW-1:0];
        else if (sum_odd < MINV)       odd_d  = MINV[DW-1:0];
        else                           odd_d  = sum_odd[DW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
            y_even  <= '0;
            y_odd   <= '0;
        end else if (accept) begin
            state_q <= odd_d;
            y_even  <= even_d;
            y_odd   <= odd_d;
        end
    end

    assert_state_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !accept |=> ($stable(state_q) && $stable(y_even) && $stable(y_odd)));

    assert_state_is_last_odd_R6: assert property (@(posedge clk) disable iff (rst)
        accept |=> (state_q == y_odd));
endmodule

// File: rtl/iir1_pair_top.sv
module iir1_pair_top #(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 coef_load,
    input  logic signed [DW-1:0] coef_in,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] x_even,
    input  logic signed [DW-1:0] x_odd,
    output logic                 out_valid,
    output logic signed [DW-1:0] y_even,
    output logic signed [DW-1:0] y_odd
);
    logic signed [DW-1:0] a_q;
    logic signed [DW-1:0] a2_q;
    logic                 accept;

    iir1_coef_unit #(.DW(DW)) u_coef (
        .clk       (clk),
        .rst       (rst),
        .coef_load (coef_load),
        .coef_in   (coef_in),
        .a_q       (a_q),
        .a2_q      (a2_q)
    );

    iir1_emit_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .accept    (accept),
        .out_valid (out_valid)
    );

    iir1_pair_path #(.DW(DW)) u_path (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .a_q    (a_q),
        .a2_q   (a2_q),
        .x_even (x_even),
        .x_odd  (x_odd),
        .y_even (y_even),
        .y_odd  (y_odd)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && y_even == 0 && y_odd == 0));
endmodule

// File: tb/iir1_pair_top_tb_top.sv
module iir1_pair_top_tb_top;
    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               coef_load = 1'b0;
    logic signed [15:0] coef_in = '0;
    logic               in_valid = 1'b0;
    logic signed [15:0] x_even = '0;
    logic signed [15:0] x_odd = '0;
    logic               out_valid;
    logic signed [15:0] y_even;
    logic signed [15:0] y_odd;

    always #5 clk = ~clk;

    iir1_pair_top dut_i (
        .clk(clk), .rst(rst), .coef_load(coef_load), .coef_in(coef_in),
        .in_valid(in_valid), .x_even(x_even), .x_odd(x_odd),
        .out_valid(out_valid), .y_even(y_even), .y_odd(y_odd)
    );

    typedef struct {
        int    ye;
        int    yo;
        int    se;
        int    so;
        bit    seq;
        string tag;
    } item_t;

    item_t sb[$];
    int n_chk  = 0;
    int n_fail = 0;
    int m_a = 0, m_a2 = 0, m_s = 0, q_s = 0;
    bit seq_on = 0;
    bit seen_out = 0;
    int last_e = 0, last_o = 0;
    int cyc = 0;

    function automatic int sat16(int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic int qm(int a, int b);
        int p;
        p = a * b;
        p = (p + 16384) >>> 15;
        return sat16(p);
    endfunction

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus; expected pair queued if a pair is sent.
    task automatic step(bit ld, int c, bit iv, int xe, int xo, string tag);
        item_t it;
        if (iv) begin
            it.ye  = sat16(xe + qm(m_a, m_s));
            it.yo  = sat16(xo + qm(m_a, xe) + qm(m_a2, m_s));
            it.se  = sat16(xe + qm(m_a, q_s));
            it.so  = sat16(xo + qm(m_a, it.se));
            it.seq = seq_on;
            it.tag = tag;
            sb.push_back(it);
            m_s = it.yo;
            q_s = it.so;
        end
        if (ld) begin
            m_a  = c;
            m_a2 = qm(c, c);
        end
        coef_load = ld;
        coef_in   = 16'(c);
        in_valid  = iv;
        x_even    = 16'(xe);
        x_odd     = 16'(xo);
        @(negedge clk);
        coef_load = 1'b0;
        in_valid  = 1'b0;
    endtask

    // Monitor: sample on falling edges, compare as results appear.
    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    n_chk++; n_fail++;
                    $display("FAIL R7 actual=out_valid expected=no result pending");
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    check({it.tag, " y_even"}, int'(y_even), it.ye);
                    check({it.tag, " y_odd"},  int'(y_odd),  it.yo);
                    if (it.seq) begin
                        n_chk++;
                        if ((int'(y_even) - it.se > 4) || (it.se - int'(y_even) > 4) ||
                            (int'(y_odd) - it.so > 4) || (it.so - int'(y_odd) > 4)) begin
                            n_fail++;
                            $display("FAIL R9 actual=%0d,%0d expected=%0d,%0d (+-4)",
                                     y_even, y_odd, it.se, it.so);
                        end
                    end
                    last_e = int'(y_even);
                    last_o = int'(y_odd);
                    seen_out = 1'b1;
                end
            end else if (seen_out) begin
                check("R7 hold y_even", int'(y_even), last_e);
                check("R7 hold y_odd",  int'(y_odd),  last_o);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d cycles expected=done", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 out_valid after reset", int'(out_valid), 0);
        check("R1 y_even after reset", int'(y_even), 0);
        // R1: zero coefficient and state pass samples through
        step(0, 0, 1, 100, -200, "R1");
        // R2: load with a pair on the same edge uses the old coefficient
        step(1, 16384, 1, 10, 20, "R2");
        // R5: a=0.5, a2=0.25, s=20 -> (10, 5)
        step(0, 0, 1, 0, 0, "R5");
        repeat (3) step(0, 0, 0, 0, 0, "R7");
        // R3: rounding of +1.5 and -1.5
        step(1, 0, 0, 0, 0, "R3");
        step(0, 0, 1, 0, 3, "R3");
        step(1, 16384, 0, 0, 0, "R3");
        step(0, 0, 1, 0, 0, "R3");
        step(1, 0, 0, 0, 0, "R3");
        step(0, 0, 1, 0, -3, "R3");
        step(1, 16384, 0, 0, 0, "R3");
        step(0, 0, 1, 0, 0, "R3");
        // R8: a = -1.0, square saturates
        step(1, 0, 1, 0, 1000, "R8");
        step(1, -32768, 0, 0, 0, "R8");
        step(0, 0, 1, 500, 200, "R8");
        // R10: positive and negative clamp
        step(1, 0, 1, 0, 30000, "R10");
        step(1, 32767, 0, 0, 0, "R10");
        step(0, 0, 1, 30000, 30000, "R10");
        step(1, 0, 1, 0, -30000, "R10");
        step(1, 32767, 0, 0, 0, "R10");
        step(0, 0, 1, -30000, -30000, "R10");
        // R4/R6/R9: random streaming with gaps and reloads
        step(1, 0, 1, 0, 0, "R4");
        q_s = m_s;
        seq_on = 1'b1;
        step(1, $urandom_range(0, 32767) - 16384, 0, 0, 0, "R4");
        for (int k = 0; k < 400; k++) begin
            bit ld;
            bit iv;
            ld = ($urandom_range(0, 19) == 0);
            iv = ($urandom_range(0, 3) != 0);
            step(ld, $urandom_range(0, 32767) - 16384, iv,
                 $urandom_range(0, 4095) - 2048, $urandom_range(0, 4095) - 2048, "R4/R6");
        end
        repeat (3) step(0, 0, 0, 0, 0, "R7");
        check("R7 scoreboard drained", sb.size(), 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule